// File: doc/BRIEF.md
# DMA Controller Control Register

This block is the top-level control register of a DMA controller that also contains a CRC engine. It holds a global DMA enable, a CRC enable, a self-clearing software reset and four priority-level enables. Software reaches it through a simple synchronous write port, and its value can be read at any time on a read-data bus. An external protection controller can lock the register through one input.

Turning a unit off is not immediate. A request to disable the DMA is held until the channel engine reports that its internal buffer has drained. When that happens, the enable bit drops and a one-cycle abort strobe is issued. A request to disable the CRC is held until the CRC engine is no longer busy. While the DMA enable reads 1, the priority-level enables and the CRC enable are frozen. A software reset is refused if either unit is still on. An accepted software reset clears the register and sends a one-cycle reset strobe to the rest of the controller. An access error strobe reports refused or blocked writes.

Top module: `dma_ctl_reg`

## Requirements
- R1: The read value places the software reset flag at bit 0, the DMA enable at bit 1, the CRC enable at bit 2, and the priority-level enables for levels 0 to 3 at bits 8 to 11. Every other bit reads 0, whatever was written to it.
- R2: After reset, the read value is 0x0000 and `err_o`, `srst_o` and `abort_o` are low.
- R3: A write with bit 2 set turns the CRC enable on at the next clock edge. A write with bit 2 clear turns it off only at the first clock edge at which `crc_busy_i` is low. Until then, bit 2 keeps reading 1.
- R4: A write with bit 1 set turns the DMA enable on at the next edge. A write with bit 1 clear keeps the bit at 1 until an edge at which `buf_empty_i` or `burst_done_i` is high. At that edge the bit clears, and `abort_o` is high for the following cycle. Writing bit 1 set while the disable is pending cancels it.
- R5: The DMA enable can be written at any time. The priority-level enables and the CRC enable take the written value only while the DMA enable reads 0.
- R6: A write made while the DMA enable reads 1 that would change the priority-level enables or the CRC enable leaves those fields unchanged. `err_o` is then high in the cycle after the write.
- R7: A write with bit 0 set while bits 1 and 2 both read 0 clears all fields and ignores the rest of the written value. For exactly the next cycle, the read value is 0x0001 and `srst_o` is high. A write presented in that cycle is ignored. A write with bit 0 clear never raises `srst_o`.
- R8: A write with bit 0 set while bit 1 or bit 2 reads 1 is discarded whole and raises `err_o` in the next cycle.
- R9: While `lock_i` is high, writes change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 16 | Write data |
| lock_i | input | 1 | Write protection from the protection controller |
| crc_busy_i | input | 1 | CRC engine is busy |
| buf_empty_i | input | 1 | DMA internal transfer buffer is empty |
| burst_done_i | input | 1 | Ongoing burst completes this cycle |
| rdata_o | output | 16 | Current register value |
| err_o | output | 1 | Access error for the previous cycle's write |
| srst_o | output | 1 | One-cycle reset strobe to the controller |
| abort_o | output | 1 | One-cycle strobe when a deferred DMA disable completes |

## Verification
The assertions check the following on every cycle:
- the DMA enable cannot fall while the buffer has not drained;
- the CRC enable cannot fall while the engine is busy;
- the priority-level field stays frozen while the DMA is enabled;
- the reset strobe lasts one cycle, reads as 0x0001, and follows a state with both units off;
- errors only follow unlocked writes, and the abort strobe marks a real falling edge of the DMA enable.

The bench scenarios cover the rest:
- the full sweep of the priority-level field and the reserved bits;
- the cycle in which a deferred disable lands;
- cancellation of a pending disable;
- a write presented during the reset cycle;
- combined writes in which the DMA disable is accepted but a protected change is refused.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DW        = 16;
  localparam int NUM_LVL   = 4;
  localparam int SRST_BIT  = 0;
  localparam int DMA_BIT   = 1;
  localparam int CRC_BIT   = 2;
  localparam int LVL_LSB   = 8;

  typedef logic [NUM_LVL-1:0] lvl_t;

  // assemble the read-back word from the individual fields
  function automatic logic [DW-1:0] pack_ctl(logic srst, logic dma, logic crc, lvl_t lvl);
    logic [DW-1:0] w;
    w = '0;
    w[SRST_BIT] = srst;
    w[DMA_BIT]  = dma;
    w[CRC_BIT]  = crc;
    w[LVL_LSB +: NUM_LVL] = lvl;
    return w;
  endfunction

  function automatic lvl_t lvl_of(logic [DW-1:0] w);
    return w[LVL_LSB +: NUM_LVL];
  endfunction
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic          wr_i,
  input  logic          lock_i,
  input  logic          hold_i,      // reset cycle in progress
  input  logic          srst_bit_i,
  input  logic          dma_bit_i,
  input  logic          crc_bit_i,
  input  lvl_t          lvl_wr_i,
  input  logic          dma_en_i,
  input  logic          crc_en_i,
  input  lvl_t          lvl_q_i,
  output logic          srst_ok_o,
  output logic          lvl_we_o,
  output logic          crc_set_o,
  output logic          crc_off_o,
  output logic          dma_set_o,
  output logic          dma_off_o,
  output logic          err_o
);
  logic acc, norm, busy, prot_change, prot_we, srst_refuse, prot_block;

  always_comb begin
    acc         = wr_i & ~lock_i & ~hold_i;
    busy        = dma_en_i | crc_en_i;
    srst_ok_o   = acc & srst_bit_i & ~busy;
    srst_refuse = acc & srst_bit_i & busy;
    norm        = acc & ~srst_bit_i;
    prot_change = (lvl_wr_i != lvl_q_i) | (crc_bit_i != crc_en_i);
    prot_block  = norm & dma_en_i & prot_change;
    prot_we     = norm & ~dma_en_i;
    lvl_we_o    = prot_we;
    crc_set_o   = prot_we & crc_bit_i;
    crc_off_o   = prot_we & ~crc_bit_i & crc_en_i;
    dma_set_o   = norm & dma_bit_i;
    dma_off_o   = norm & ~dma_bit_i & dma_en_i;
    err_o       = srst_refuse | prot_block;
  end
endmodule

// File: rtl/dma_ctl_drain_en.sv
// Enable bit whose clear waits for the owning unit to go idle.
module dma_ctl_drain_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic off_i,
  input  logic idle_i,
  output logic en_o,
  output logic pend_o
);
  logic want_off;
  assign want_off = (off_i | pend_o) & en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
    end else if (clr_i) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
    end else if (set_i) begin
      en_o   <= 1'b1;
      pend_o <= 1'b0;
    end else if (want_off) begin
      if (idle_i) begin
        en_o   <= 1'b0;
        pend_o <= 1'b0;
      end else begin
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          lock_i,
  input  logic          crc_busy_i,
  input  logic          buf_empty_i,
  input  logic          burst_done_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          srst_o,
  output logic          abort_o
);
  // named internal events
  logic srst_ok, lvl_we, crc_set, crc_off, dma_set, dma_off, wr_err;
  logic dma_en, crc_en, dma_pend, crc_pend, dma_idle, crc_idle;
  logic srst_q, err_q, dma_prev_q;
  lvl_t lvl_q;

  assign dma_idle = buf_empty_i | burst_done_i;
  assign crc_idle = ~crc_busy_i;

  dma_ctl_decode u_dec (
    .wr_i       (wr_i),
    .lock_i     (lock_i),
    .hold_i     (srst_q),
    .srst_bit_i (wdata_i[SRST_BIT]),
    .dma_bit_i  (wdata_i[DMA_BIT]),
    .crc_bit_i  (wdata_i[CRC_BIT]),
    .lvl_wr_i   (lvl_of(wdata_i)),
    .dma_en_i   (dma_en),
    .crc_en_i   (crc_en),
    .lvl_q_i    (lvl_q),
    .srst_ok_o  (srst_ok),
    .lvl_we_o   (lvl_we),
    .crc_set_o  (crc_set),
    .crc_off_o  (crc_off),
    .dma_set_o  (dma_set),
    .dma_off_o  (dma_off),
    .err_o      (wr_err)
  );

  dma_ctl_drain_en u_dma_en (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (srst_ok),
    .set_i (dma_set), .off_i (dma_off), .idle_i (dma_idle),
    .en_o  (dma_en), .pend_o (dma_pend)
  );

  dma_ctl_drain_en u_crc_en (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (srst_ok),
    .set_i (crc_set), .off_i (crc_off), .idle_i (crc_idle),
    .en_o  (crc_en), .pend_o (crc_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= '0;
      srst_q     <= 1'b0;
      err_q      <= 1'b0;
      dma_prev_q <= 1'b0;
    end else begin
      srst_q     <= srst_ok;
      err_q      <= wr_err;
      dma_prev_q <= dma_en;
      if (srst_ok)     lvl_q <= '0;
      else if (lvl_we) lvl_q <= lvl_of(wdata_i);
    end
  end

  assign rdata_o = pack_ctl(srst_q, dma_en, crc_en, lvl_q);
  assign err_o   = err_q;
  assign srst_o  = srst_q;
  assign abort_o = dma_prev_q & ~dma_en;
endmodule

// File: rtl/dma_ctl_reg_chk.sv
module dma_ctl_reg_chk
  import dma_ctl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          lock_i,
  input logic          crc_busy_i,
  input logic          buf_empty_i,
  input logic          burst_done_i,
  input logic [DW-1:0] rdata_o,
  input logic          err_o,
  input logic          srst_o,
  input logic          abort_o
);
  assert_dma_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DMA_BIT] && !buf_empty_i && !burst_done_i) |=> rdata_o[DMA_BIT]);

  assert_crc_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[CRC_BIT] && crc_busy_i) |=> rdata_o[CRC_BIT]);

  assert_lvl_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DMA_BIT] |=> $stable(rdata_o[LVL_LSB +: NUM_LVL]));

  assert_srst_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !srst_o);

  assert_srst_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> (rdata_o == DW'(1)));

  assert_srst_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_o) |-> $past(rdata_o[CRC_BIT:DMA_BIT] == 2'b00));

  assert_lock_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lock_i) |=> !err_o);

  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(wr_i && !lock_i));

  assert_abort_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!rdata_o[DMA_BIT] && $past(rdata_o[DMA_BIT])));
endmodule

bind dma_ctl_reg dma_ctl_reg_chk u_chk (.*);

// File: tb/test_dma_ctl_reg.sv
`timescale 1ns/1ps
module test_dma_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, lock = 1'b0, crc_busy = 1'b0, buf_empty = 1'b0, burst_done = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err, srst, abort;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dma_ctl_reg i_dma_ctl_reg (
    .clk_i (clk), .rst_ni (rst_n), .wr_i (wr), .wdata_i (wdata), .lock_i (lock),
    .crc_busy_i (crc_busy), .buf_empty_i (buf_empty), .burst_done_i (burst_done),
    .rdata_o (rdata), .err_o (err), .srst_o (srst), .abort_o (abort)
  );

  // expected read word computed from field values
  function automatic logic [15:0] exp_word(bit s, bit d, bit c, int lvl);
    return 16'((lvl % 16) * 256 + c * 4 + d * 2 + s);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write presented for one cycle; returns at the negedge after the capturing edge
  task automatic wr1(logic [15:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R2 reset state
    chk("R2 rdata", rdata, 16'h0000);
    chk("R2 strobes", {13'd0, err, srst, abort}, 16'h0000);

    // R1/R5 sweep of the level field with reserved bits set, units off
    for (int l = 0; l < 16; l++) begin
      wr1(16'(l * 256) | 16'hF0F8);
      chk("R1 level sweep", rdata, exp_word(0, 0, 0, l));
      chk("R7 no srst on bit0=0", {15'd0, srst}, 16'h0);
    end

    // R4 enable DMA with level 5
    wr1(16'h0502);
    chk("R4 dma set", rdata, exp_word(0, 1, 0, 5));

    // R6 protected changes blocked
    wr1(16'h0A02);
    chk("R6 lvl blocked", rdata, exp_word(0, 1, 0, 5));
    chk("R6 err", {15'd0, err}, 16'h1);
    wr1(16'h0506);
    chk("R6 crc blocked", rdata, exp_word(0, 1, 0, 5));
    chk("R6 err crc", {15'd0, err}, 16'h1);
    wr1(16'h0502);
    chk("R6 no err on same value", {15'd0, err}, 16'h0);

    // R8 software reset refused while DMA on
    wr1(16'h0001);
    chk("R8 err", {15'd0, err}, 16'h1);
    chk("R8 no srst", {15'd0, srst}, 16'h0);
    chk("R8 unchanged", rdata, exp_word(0, 1, 0, 5));

    // R4 deferred disable
    wr1(16'h0500);
    chk("R4 held", rdata, exp_word(0, 1, 0, 5));
    idle(3);
    chk("R4 still held", rdata, exp_word(0, 1, 0, 5));
    burst_done = 1'b1;
    @(negedge clk); burst_done = 1'b0;
    chk("R4 cleared at burst end", rdata, exp_word(0, 0, 0, 5));
    chk("R4 abort pulse", {15'd0, abort}, 16'h1);
    idle(1);
    chk("R4 abort single", {15'd0, abort}, 16'h0);

    // R4 cancellation of a pending disable
    wr1(16'h0502);
    wr1(16'h0500);
    wr1(16'h0502);
    burst_done = 1'b1;
    @(negedge clk); burst_done = 1'b0;
    chk("R4 cancel keeps enable", rdata, exp_word(0, 1, 0, 5));

    // R6/R4 combined: dma disable accepted, level change refused
    buf_empty = 1'b1;
    wr1(16'h0A00);
    chk("R6 combined fields", rdata, exp_word(0, 0, 0, 5));
    chk("R6 combined err", {15'd0, err}, 16'h1);
    chk("R4 immediate abort", {15'd0, abort}, 16'h1);
    buf_empty = 1'b0;

    // R3 CRC enable and deferred disable
    wr1(16'h0504);
    chk("R3 crc set", rdata, exp_word(0, 0, 1, 5));
    wr1(16'h0001);
    chk("R8 refused crc on", rdata, exp_word(0, 0, 1, 5));
    chk("R8 err crc on", {15'd0, err}, 16'h1);
    crc_busy = 1'b1;
    wr1(16'h0500);
    idle(2);
    chk("R3 held while busy", rdata, exp_word(0, 0, 1, 5));
    crc_busy = 1'b0;
    @(negedge clk);
    chk("R3 cleared when idle", rdata, exp_word(0, 0, 0, 5));

    // R9 lock
    lock = 1'b1;
    wr1(16'h0C02);
    chk("R9 locked write", rdata, exp_word(0, 0, 0, 5));
    chk("R9 no err", {15'd0, err}, 16'h0);
    wr1(16'h0001);
    chk("R9 locked srst", {15'd0, srst}, 16'h0);
    lock = 1'b0;

    // R7 accepted software reset, with a write during the reset cycle
    @(negedge clk); wr = 1'b1; wdata = 16'h0001;
    @(negedge clk); wdata = 16'h0302;
    chk("R7 reset cycle value", rdata, 16'h0001);
    chk("R7 srst strobe", {15'd0, srst}, 16'h1);
    chk("R7 no err", {15'd0, err}, 16'h0);
    @(negedge clk); wr = 1'b0;
    chk("R7 cleared, write ignored", rdata, 16'h0000);
    chk("R7 srst single", {15'd0, srst}, 16'h0);

    summary();
    $finish;
  end
endmodule